// File: doc/BRIEF.md
# Line-Port Loopback Path Selector

This block sits between the line pins of one DS3/E3 port and the framing logic behind them. It steers the port's signals through normal operation or through one of several diagnostic loopbacks. A 3-bit mode field chooses the path.

Terminal loopback turns the transmit line signals back into the receive side next to the pins. Line loopback sends the received line signals straight back out of the transmit pins, with the data retimed. Payload loopback copies the received payload into the transmit framer input. Another encoding turns on line loopback together with a separate diagnostic loopback, which lives in a neighbouring block and is enabled from here.

The block also does the following per mode:
- It can substitute an unframed all-ones alarm pattern on the receive payload.
- It can force the transmit data-enable and start-of-frame strobes to zero.
- It gates the transmit cell/packet flow and flags when system-side cells or packets are being discarded.

All control inputs, including the mode field, are captured on the port clock. Every routing decision follows the registered copy, so a change takes effect at one clock edge and the alarm pattern never starts or stops in the middle of a cycle.

Top module: `lport_loop_sel`

## Requirements
- R1: With mode 3'b001 and loop timing off, the receive-side outputs (clock, positive rail, negative rail, overhead mask) carry the transmit line inputs instead of the receive pins.
- R2: While loop timing is on, mode 3'b001 leaves the receive side on the receive pins, as in normal operation.
- R3: Modes 3'b010 and 3'b110 both enable line loopback. `dlb_en_o` is 1 only for 3'b110.
- R4: In line loopback, `tx_lclk_o` follows `rx_lclk_i` directly. `tx_lpos_o`/`tx_lneg_o` carry `rx_lpos_i`/`rx_lneg_i` as sampled at the previous `clk` rising edge. `tx_lohm_o` is 0.
- R5: With `ais_en_i` set, `rx_pay_o` is all ones in line loopback (mode 3'b010) and in effective payload loopback. It is never all-ones substituted in mode 3'b110, nor when `ais_en_i` is clear.
- R6: In payload loopback (mode 3'b011, `ohm_mode_i`=0), `tx_fr_pay_o` carries `rx_pay_i` and `tx_fr_sof_o` is 0 regardless of `tx_sof_i`.
- R7: With `ohm_mode_i`=1, mode 3'b011 behaves as normal operation: payload, strobes and flow are unaltered.
- R8: In effective payload loopback with `strobe_dis_i`=1, `tx_den_o` and `tx_sofo_o` are 0. With `strobe_dis_i`=0 they follow `tx_den_int_i`/`tx_sofo_int_i`.
- R9: In effective payload loopback with `framed_i`=1, `flow_dis_i`=1 drives `flow_en_o` to 0 and `discard_o` to 0. `flow_dis_i`=0 keeps `flow_en_o` at 1 and drives `discard_o` to 1. With `framed_i`=0, `flow_en_o`=1 and `discard_o`=0.
- R10: Modes 3'b000, 3'b100, 3'b101 and 3'b111 pass every path unaltered, with `dlb_en_o`=0, `flow_en_o`=1 and `discard_o`=0. This is also the state under reset.
- R11: A change on the mode or control inputs alters the outputs only after the next `clk` rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Port clock (receive-domain), captures controls and retimes data |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_i | input | 3 | Loopback mode field |
| loopt_i | input | 1 | Loop-timed operation active |
| ais_en_i | input | 1 | Allow automatic all-ones alarm on receive payload |
| ohm_mode_i | input | 1 | Port runs an overhead-mask framing mode |
| framed_i | input | 1 | Port runs a framed (cell/packet) mode |
| strobe_dis_i | input | 1 | Force transmit strobes low during payload loopback |
| flow_dis_i | input | 1 | Disable transmit cell/packet flow during payload loopback |
| tx_lclk_i | input | 1 | Transmit line clock from the formatter |
| tx_lpos_i | input | 1 | Transmit positive rail from the formatter |
| tx_lneg_i | input | 1 | Transmit negative rail from the formatter |
| tx_lohm_i | input | 1 | Transmit overhead-mask bit from the formatter |
| tx_lclk_o | output | 1 | Transmit line clock to the pins |
| tx_lpos_o | output | 1 | Transmit positive rail to the pins |
| tx_lneg_o | output | 1 | Transmit negative rail to the pins |
| tx_lohm_o | output | 1 | Transmit overhead-mask bit to the pins |
| rx_lclk_i | input | 1 | Receive line clock pin |
| rx_lpos_i | input | 1 | Receive positive rail pin |
| rx_lneg_i | input | 1 | Receive negative rail pin |
| rx_lohm_i | input | 1 | Receive overhead-mask pin |
| rx_lclk_o | output | 1 | Receive line clock toward decoder/framer |
| rx_lpos_o | output | 1 | Receive positive rail toward decoder/framer |
| rx_lneg_o | output | 1 | Receive negative rail toward decoder/framer |
| rx_lohm_o | output | 1 | Receive overhead-mask bit toward framer |
| rx_pay_i | input | PAY_W | Payload from the receive framer |
| rx_pay_o | output | PAY_W | Payload toward the receive cell/packet logic |
| tx_pay_i | input | PAY_W | Payload from the transmit system side |
| tx_fr_pay_o | output | PAY_W | Payload into the transmit framer |
| tx_sof_i | input | 1 | Transmit start-of-frame input |
| tx_fr_sof_o | output | 1 | Start-of-frame handed to the transmit framer |
| tx_den_int_i | input | 1 | Internal transmit data-enable strobe |
| tx_sofo_int_i | input | 1 | Internal transmit start-of-frame output strobe |
| tx_den_o | output | 1 | Transmit data-enable output strobe |
| tx_sofo_o | output | 1 | Transmit start-of-frame output strobe |
| flow_en_o | output | 1 | Transmit cell/packet flow enable |
| discard_o | output | 1 | System-side cells/packets are being discarded |
| dlb_en_o | output | 1 | Enable for the neighbouring diagnostic loopback |

## Verification
The assertions that compare line outputs with pin values sampled at the previous edge take for granted that those pins change only between edges, never at the rising edge of `clk`. The bench drives every input on the falling edge and samples one time unit after the rising edge. The assertion on receive-side routing under loop timing assumes loop timing was already set at the previous edge. The stimulus holds control values for at least one full cycle before checking, so that holds.

// File: rtl/lport_loop_pkg.sv
package lport_loop_pkg;

    typedef enum logic [2:0] {
        MODE_NORMAL  = 3'b000,
        MODE_TERM    = 3'b001,
        MODE_LINE    = 3'b010,
        MODE_PAYLOAD = 3'b011,
        MODE_DIAG_LN = 3'b110
    } lp_mode_e;

    typedef struct packed {
        logic [2:0] mode;
        logic       loopt;
        logic       ais_en;
        logic       ohm_mode;
        logic       framed;
        logic       strobe_dis;
        logic       flow_dis;
    } lp_ctrl_t;

    typedef struct packed {
        logic tlb;
        logic llb;
        logic dlb;
        logic plb;
        logic ais;
    } lp_dec_t;

    typedef struct packed {
        logic pos;
        logic neg;
    } lp_rail_t;

endpackage

// File: rtl/lp_mode_decode.sv
module lp_mode_decode
    import lport_loop_pkg::*;
(
    input  lp_ctrl_t ctrl,
    output lp_dec_t  dec
);
    logic line_sel;
    logic term_sel;
    logic pay_sel;

    always_comb begin
        // low two bits 2'b10 select line loopback, top bit is don't-care
        line_sel = (ctrl.mode[1:0] == 2'b10);
        term_sel = (ctrl.mode == MODE_TERM);
        pay_sel  = (ctrl.mode == MODE_PAYLOAD);

        dec.tlb = term_sel && !ctrl.loopt;
        dec.llb = line_sel;
        dec.dlb = (ctrl.mode == MODE_DIAG_LN);
        dec.plb = pay_sel && !ctrl.ohm_mode;
        dec.ais = ctrl.ais_en && ((line_sel && !dec.dlb) || dec.plb);
    end
endmodule

// File: rtl/lp_line_mux.sv
module lp_line_mux
    import lport_loop_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic tlb,
    input  logic llb,
    input  logic tx_lclk_i,
    input  logic tx_lpos_i,
    input  logic tx_lneg_i,
    input  logic tx_lohm_i,
    output logic tx_lclk_o,
    output logic tx_lpos_o,
    output logic tx_lneg_o,
    output logic tx_lohm_o,
    input  logic rx_lclk_i,
    input  logic rx_lpos_i,
    input  logic rx_lneg_i,
    input  logic rx_lohm_i,
    output logic rx_lclk_o,
    output logic rx_lpos_o,
    output logic rx_lneg_o,
    output logic rx_lohm_o
);
    lp_rail_t ret_d, ret_q;

    always_comb begin
        ret_d.pos = rx_lpos_i;
        ret_d.neg = rx_lneg_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ret_q <= '0;
        else        ret_q <= ret_d;
    end

    always_comb begin
        if (tlb) begin
            rx_lclk_o = tx_lclk_i;
            rx_lpos_o = tx_lpos_i;
            rx_lneg_o = tx_lneg_i;
            rx_lohm_o = tx_lohm_i;
        end else begin
            rx_lclk_o = rx_lclk_i;
            rx_lpos_o = rx_lpos_i;
            rx_lneg_o = rx_lneg_i;
            rx_lohm_o = rx_lohm_i;
        end
        if (llb) begin
            tx_lclk_o = rx_lclk_i;
            tx_lpos_o = ret_q.pos;
            tx_lneg_o = ret_q.neg;
            tx_lohm_o = 1'b0;
        end else begin
            tx_lclk_o = tx_lclk_i;
            tx_lpos_o = tx_lpos_i;
            tx_lneg_o = tx_lneg_i;
            tx_lohm_o = tx_lohm_i;
        end
    end

    // R4: retimed rails in line loopback
    a_r4_retime: assert property (@(posedge clk) disable iff (!rst_n)
        (llb && $past(llb)) |-> (tx_lpos_o == $past(rx_lpos_i) && tx_lneg_o == $past(rx_lneg_i)));

    // R4: overhead-mask output held low in line loopback
    a_r4_ohm_low: assert property (@(posedge clk) disable iff (!rst_n)
        llb |-> !tx_lohm_o);
endmodule

// File: rtl/lp_payload_mux.sv
module lp_payload_mux
    import lport_loop_pkg::*;
#(
    parameter int PAY_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  lp_dec_t          dec,
    input  logic             framed,
    input  logic             strobe_dis,
    input  logic             flow_dis,
    input  logic [PAY_W-1:0] rx_pay_i,
    output logic [PAY_W-1:0] rx_pay_o,
    input  logic [PAY_W-1:0] tx_pay_i,
    output logic [PAY_W-1:0] tx_fr_pay_o,
    input  logic             tx_sof_i,
    output logic             tx_fr_sof_o,
    input  logic             tx_den_int_i,
    input  logic             tx_sofo_int_i,
    output logic             tx_den_o,
    output logic             tx_sofo_o,
    output logic             flow_en_o,
    output logic             discard_o
);
    localparam logic [PAY_W-1:0] AIS_WORD = {PAY_W{1'b1}};

    logic strobe_kill;
    logic flow_gate;

    always_comb begin
        strobe_kill = dec.plb && strobe_dis;
        flow_gate   = dec.plb && framed;

        rx_pay_o    = dec.ais ? AIS_WORD : rx_pay_i;
        tx_fr_pay_o = dec.plb ? rx_pay_i : tx_pay_i;
        tx_fr_sof_o = dec.plb ? 1'b0 : tx_sof_i;
        tx_den_o    = strobe_kill ? 1'b0 : tx_den_int_i;
        tx_sofo_o   = strobe_kill ? 1'b0 : tx_sofo_int_i;
        flow_en_o   = !(flow_gate && flow_dis);
        discard_o   = flow_gate && !flow_dis;
    end

    // R9: discarding and a disabled flow never coexist
    a_r9_flow_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(discard_o && !flow_en_o));

    // R5: dual loopback never substitutes the alarm word
    a_r5_no_ais_dual: assert property (@(posedge clk) disable iff (!rst_n)
        (dec.dlb && dec.llb) |-> (rx_pay_o == rx_pay_i));

    // R8: strobes forced low
    a_r8_strobes_low: assert property (@(posedge clk) disable iff (!rst_n)
        (dec.plb && strobe_dis) |-> (!tx_den_o && !tx_sofo_o));
endmodule

// File: rtl/lport_loop_sel.sv
module lport_loop_sel
    import lport_loop_pkg::*;
#(
    parameter int PAY_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [2:0]       mode_i,
    input  logic             loopt_i,
    input  logic             ais_en_i,
    input  logic             ohm_mode_i,
    input  logic             framed_i,
    input  logic             strobe_dis_i,
    input  logic             flow_dis_i,
    input  logic             tx_lclk_i,
    input  logic             tx_lpos_i,
    input  logic             tx_lneg_i,
    input  logic             tx_lohm_i,
    output logic             tx_lclk_o,
    output logic             tx_lpos_o,
    output logic             tx_lneg_o,
    output logic             tx_lohm_o,
    input  logic             rx_lclk_i,
    input  logic             rx_lpos_i,
    input  logic             rx_lneg_i,
    input  logic             rx_lohm_i,
    output logic             rx_lclk_o,
    output logic             rx_lpos_o,
    output logic             rx_lneg_o,
    output logic             rx_lohm_o,
    input  logic [PAY_W-1:0] rx_pay_i,
    output logic [PAY_W-1:0] rx_pay_o,
    input  logic [PAY_W-1:0] tx_pay_i,
    output logic [PAY_W-1:0] tx_fr_pay_o,
    input  logic             tx_sof_i,
    output logic             tx_fr_sof_o,
    input  logic             tx_den_int_i,
    input  logic             tx_sofo_int_i,
    output logic             tx_den_o,
    output logic             tx_sofo_o,
    output logic             flow_en_o,
    output logic             discard_o,
    output logic             dlb_en_o
);
    lp_ctrl_t ctrl_d, ctrl_q;
    lp_dec_t  dec;

    always_comb begin
        ctrl_d.mode       = mode_i;
        ctrl_d.loopt      = loopt_i;
        ctrl_d.ais_en     = ais_en_i;
        ctrl_d.ohm_mode   = ohm_mode_i;
        ctrl_d.framed     = framed_i;
        ctrl_d.strobe_dis = strobe_dis_i;
        ctrl_d.flow_dis   = flow_dis_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctrl_q <= '0;
        else        ctrl_q <= ctrl_d;
    end

    lp_mode_decode i_dec (
        .ctrl (ctrl_q),
        .dec  (dec)
    );

    lp_line_mux i_line (
        .clk       (clk),
        .rst_n     (rst_n),
        .tlb       (dec.tlb),
        .llb       (dec.llb),
        .tx_lclk_i (tx_lclk_i),
        .tx_lpos_i (tx_lpos_i),
        .tx_lneg_i (tx_lneg_i),
        .tx_lohm_i (tx_lohm_i),
        .tx_lclk_o (tx_lclk_o),
        .tx_lpos_o (tx_lpos_o),
        .tx_lneg_o (tx_lneg_o),
        .tx_lohm_o (tx_lohm_o),
        .rx_lclk_i (rx_lclk_i),
        .rx_lpos_i (rx_lpos_i),
        .rx_lneg_i (rx_lneg_i),
        .rx_lohm_i (rx_lohm_i),
        .rx_lclk_o (rx_lclk_o),
        .rx_lpos_o (rx_lpos_o),
        .rx_lneg_o (rx_lneg_o),
        .rx_lohm_o (rx_lohm_o)
    );

    lp_payload_mux #(.PAY_W(PAY_W)) i_pay (
        .clk           (clk),
        .rst_n         (rst_n),
        .dec           (dec),
        .framed        (ctrl_q.framed),
        .strobe_dis    (ctrl_q.strobe_dis),
        .flow_dis      (ctrl_q.flow_dis),
        .rx_pay_i      (rx_pay_i),
        .rx_pay_o      (rx_pay_o),
        .tx_pay_i      (tx_pay_i),
        .tx_fr_pay_o   (tx_fr_pay_o),
        .tx_sof_i      (tx_sof_i),
        .tx_fr_sof_o   (tx_fr_sof_o),
        .tx_den_int_i  (tx_den_int_i),
        .tx_sofo_int_i (tx_sofo_int_i),
        .tx_den_o      (tx_den_o),
        .tx_sofo_o     (tx_sofo_o),
        .flow_en_o     (flow_en_o),
        .discard_o     (discard_o)
    );

    assign dlb_en_o = dec.dlb;

    // R2: loop timing keeps receive side on the pins
    a_r2_tlb_blocked: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(loopt_i) && $past(mode_i) == MODE_TERM) |->
            (rx_lpos_o == rx_lpos_i && rx_lclk_o == rx_lclk_i));

    // R3: diagnostic enable only with line loopback active
    a_r3_dlb_with_llb: assert property (@(posedge clk) disable iff (!rst_n)
        dlb_en_o |-> (tx_lclk_o == rx_lclk_i));

    // R11: diagnostic enable follows the mode seen at the previous edge
    a_r11_dlb_latency: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(mode_i) != MODE_DIAG_LN) |-> !dlb_en_o);
endmodule

// File: tb/test_lport_loop_sel.sv
module test_lport_loop_sel;
    localparam int CLK_P = 10;
    localparam int PAY_W = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [2:0] mode_i = 3'b000;
    logic loopt_i = 0, ais_en_i = 0, ohm_mode_i = 0, framed_i = 0;
    logic strobe_dis_i = 0, flow_dis_i = 0;
    logic tx_lclk_i = 0, tx_lpos_i = 0, tx_lneg_i = 0, tx_lohm_i = 0;
    logic rx_lclk_i = 0, rx_lpos_i = 0, rx_lneg_i = 0, rx_lohm_i = 0;
    logic tx_lclk_o, tx_lpos_o, tx_lneg_o, tx_lohm_o;
    logic rx_lclk_o, rx_lpos_o, rx_lneg_o, rx_lohm_o;
    logic [PAY_W-1:0] rx_pay_i = '0, tx_pay_i = '0, rx_pay_o, tx_fr_pay_o;
    logic tx_sof_i = 0, tx_den_int_i = 0, tx_sofo_int_i = 0;
    logic tx_fr_sof_o, tx_den_o, tx_sofo_o, flow_en_o, discard_o, dlb_en_o;

    int n_cmp = 0;
    int n_bad = 0;

    always #(CLK_P/2) clk = ~clk;

    lport_loop_sel #(.PAY_W(PAY_W)) i_lport_loop_sel (
        .clk(clk), .rst_n(rst_n), .mode_i(mode_i), .loopt_i(loopt_i),
        .ais_en_i(ais_en_i), .ohm_mode_i(ohm_mode_i), .framed_i(framed_i),
        .strobe_dis_i(strobe_dis_i), .flow_dis_i(flow_dis_i),
        .tx_lclk_i(tx_lclk_i), .tx_lpos_i(tx_lpos_i), .tx_lneg_i(tx_lneg_i), .tx_lohm_i(tx_lohm_i),
        .tx_lclk_o(tx_lclk_o), .tx_lpos_o(tx_lpos_o), .tx_lneg_o(tx_lneg_o), .tx_lohm_o(tx_lohm_o),
        .rx_lclk_i(rx_lclk_i), .rx_lpos_i(rx_lpos_i), .rx_lneg_i(rx_lneg_i), .rx_lohm_i(rx_lohm_i),
        .rx_lclk_o(rx_lclk_o), .rx_lpos_o(rx_lpos_o), .rx_lneg_o(rx_lneg_o), .rx_lohm_o(rx_lohm_o),
        .rx_pay_i(rx_pay_i), .rx_pay_o(rx_pay_o), .tx_pay_i(tx_pay_i), .tx_fr_pay_o(tx_fr_pay_o),
        .tx_sof_i(tx_sof_i), .tx_fr_sof_o(tx_fr_sof_o), .tx_den_int_i(tx_den_int_i),
        .tx_sofo_int_i(tx_sofo_int_i), .tx_den_o(tx_den_o), .tx_sofo_o(tx_sofo_o),
        .flow_en_o(flow_en_o), .discard_o(discard_o), .dlb_en_o(dlb_en_o)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic set_ctrl(input logic [2:0] m, input logic lt, input logic ae, input logic ohm,
                            input logic fr, input logic sd, input logic fd);
        mode_i = m; loopt_i = lt; ais_en_i = ae; ohm_mode_i = ohm;
        framed_i = fr; strobe_dis_i = sd; flow_dis_i = fd;
    endtask

    task automatic data_pat(input int k);
        tx_lclk_i = 1'b1; tx_lpos_i = k[0]; tx_lneg_i = ~k[0]; tx_lohm_i = 1'b1;
        rx_lclk_i = 1'b0; rx_lpos_i = ~k[1]; rx_lneg_i = k[1]; rx_lohm_i = 1'b0;
        rx_pay_i = 8'h3C ^ 8'(k); tx_pay_i = 8'hA5 ^ 8'(k);
        tx_sof_i = 1'b1; tx_den_int_i = 1'b1; tx_sofo_int_i = 1'b1;
    endtask

    task automatic t_reset;
        data_pat(0);
        #1;
        chk("R10 reset dlb", dlb_en_o, 0);
        chk("R10 reset rx_pay", rx_pay_o, rx_pay_i);
        chk("R10 reset flow", {flow_en_o, discard_o}, 2'b10);
        chk("R10 reset tx_lpos", tx_lpos_o, tx_lpos_i);
    endtask

    task automatic t_sweep;
        for (int m = 0; m < 8; m++) begin
            for (int lt = 0; lt < 2; lt++) begin
                logic e_tlb, e_llb, e_dlb, e_plb, e_ais;
                logic cap_pos, cap_neg;
                @(negedge clk);
                set_ctrl(3'(m), 1'(lt), 1'b1, 1'b0, 1'b1, 1'b1, 1'b0);
                data_pat(m + lt);
                cap_pos = rx_lpos_i; cap_neg = rx_lneg_i;
                e_tlb = (m == 1) && (lt == 0);
                e_llb = (m[1:0] == 2'b10);
                e_dlb = (m == 6);
                e_plb = (m == 3);
                e_ais = (e_llb && !e_dlb) || e_plb;
                @(posedge clk); #1;
                chk(e_tlb ? "R1 rx_lclk" : "R2 rx_lclk", rx_lclk_o, e_tlb ? tx_lclk_i : rx_lclk_i);
                chk(e_tlb ? "R1 rx_lpos" : "R10 rx_lpos", rx_lpos_o, e_tlb ? tx_lpos_i : rx_lpos_i);
                chk("R1 rx_lneg", rx_lneg_o, e_tlb ? tx_lneg_i : rx_lneg_i);
                chk("R1 rx_lohm", rx_lohm_o, e_tlb ? tx_lohm_i : rx_lohm_i);
                chk("R3 dlb_en", dlb_en_o, e_dlb);
                chk("R4 tx_lclk", tx_lclk_o, e_llb ? rx_lclk_i : tx_lclk_i);
                chk("R4 tx_lohm", tx_lohm_o, e_llb ? 1'b0 : tx_lohm_i);
                chk("R5 rx_pay", rx_pay_o, e_ais ? 8'hFF : rx_pay_i);
                chk("R6 tx_fr_pay", tx_fr_pay_o, e_plb ? rx_pay_i : tx_pay_i);
                chk("R6 tx_fr_sof", tx_fr_sof_o, e_plb ? 1'b0 : 1'b1);
                chk("R8 strobes", {tx_den_o, tx_sofo_o}, e_plb ? 2'b00 : 2'b11);
                chk("R9 flow", {flow_en_o, discard_o}, e_plb ? 2'b11 : 2'b10);
                // change pins after the edge: retimed output must not move
                rx_lpos_i = ~cap_pos; rx_lneg_i = ~cap_neg;
                #1;
                chk("R4 tx_lpos", tx_lpos_o, e_llb ? cap_pos : tx_lpos_i);
                chk("R4 tx_lneg", tx_lneg_o, e_llb ? cap_neg : tx_lneg_i);
            end
        end
    endtask

    task automatic t_ohm;
        @(negedge clk);
        set_ctrl(3'b011, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0);
        data_pat(5);
        @(posedge clk); #1;
        chk("R7 tx_fr_pay", tx_fr_pay_o, tx_pay_i);
        chk("R7 rx_pay", rx_pay_o, rx_pay_i);
        chk("R7 strobes", {tx_den_o, tx_sofo_o, tx_fr_sof_o}, 3'b111);
        chk("R7 flow", {flow_en_o, discard_o}, 2'b10);
    endtask

    task automatic t_plb_opts;
        @(negedge clk);
        set_ctrl(3'b011, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1);
        data_pat(2);
        tx_den_int_i = 1'b1; tx_sofo_int_i = 1'b0;
        @(posedge clk); #1;
        chk("R5 no ais when disabled", rx_pay_o, rx_pay_i);
        chk("R8 strobes pass", {tx_den_o, tx_sofo_o}, 2'b10);
        chk("R9 flow disabled", {flow_en_o, discard_o}, 2'b00);
        @(negedge clk);
        framed_i = 1'b0; flow_dis_i = 1'b0;
        @(posedge clk); #1;
        chk("R9 unframed", {flow_en_o, discard_o}, 2'b10);
        @(negedge clk);
        set_ctrl(3'b010, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
        @(posedge clk); #1;
        chk("R5 llb no ais when disabled", rx_pay_o, rx_pay_i);
    endtask

    task automatic t_latency;
        @(negedge clk);
        set_ctrl(3'b000, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
        data_pat(1);
        @(posedge clk);
        @(negedge clk);
        mode_i = 3'b001;
        #1;
        chk("R11 before edge", rx_lpos_o, rx_lpos_i);
        @(posedge clk); #1;
        chk("R11 after edge", rx_lpos_o, tx_lpos_i);
        @(negedge clk);
        mode_i = 3'b010;
        #1;
        chk("R11 ais before edge", rx_pay_o, rx_pay_i);
        @(posedge clk); #1;
        chk("R11 ais after edge", rx_pay_o, 8'hFF);
    endtask

    initial begin
        t_reset;
        #(CLK_P*3);
        @(negedge clk);
        rst_n = 1'b1;
        t_sweep;
        t_ohm;
        t_plb_opts;
        t_latency;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #(CLK_P*100000);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule